// File: doc/BRIEF.md
# Bit-Serial Accumulator Datapath

This block is the arithmetic core of a small 12-bit accumulator machine. It works one bit at a time. It holds three pieces of state: the accumulator, an operand shift register, and a single flag bit. The flag serves as the condition flag and also as the serial carry. The surrounding sequencer tells the block which machine phase is active and pulses a strobe.

On a strobe in the setup phase, the flag is seeded with a value chosen by the opcode, and the bit counter restarts. On each of the next twelve strobes in the arithmetic phase, one result bit is made from the low bits of the accumulator and the operand, plus the flag. That bit enters the accumulator at its top end while both registers shift toward bit 0. A one-cycle done pulse marks the twelfth step.

The operand register can be loaded in parallel outside the arithmetic phase. Four operations are supported: load, NOR, add and a one-place shift. Opcodes whose top bit is set leave the accumulator and the flag alone.

Top module: `serial_acc_alu`

## Requirements
- R1: After reset the accumulator, flag, operand register and done are 0, and the bit counter is idle, so arithmetic-phase strobes before any setup strobe change nothing.
- R2: When `x_load` is high and the phase is not arithmetic (phase code 2'b10), the operand register takes `x_in` at the clock edge. When the phase is arithmetic, `x_load` is ignored.
- R3: A setup strobe (phase code 2'b01) restarts the bit counter and seeds the flag: 1 for load (3'b000) and NOR (3'b001), 0 for add (3'b010), and operand bit 0 for shift (3'b011).
- R4: Each arithmetic strobe shifts the accumulator one place toward bit 0 and writes the result bit into bit 11. It also shifts the operand toward bit 0, filling its bit 11 with 0.
- R5: For load, the result bit is operand bit 0 and the flag holds. After 12 steps the accumulator equals the operand and the flag is 1.
- R6: For NOR, the result bit is the NOR of accumulator bit 0 and operand bit 0, and the flag holds. The final accumulator is ~(A|X) and the final flag is 1.
- R7: For add, the result bit is the XOR of both low bits and the flag, and the flag becomes their majority. The final accumulator is (A+X) mod 4096 and the final flag is the carry out of bit 11.
- R8: For shift, the result bit is the current flag and the flag becomes operand bit 0. The final accumulator is {X[10:0], X[0]} and the final flag is X[11].
- R9: Opcodes with bit 2 set never change the accumulator or the flag.
- R10: `done` is high for exactly the one cycle after the twelfth arithmetic strobe. Further arithmetic strobes have no effect until the next setup strobe.
- R11: If a parallel load and a setup strobe happen in the same cycle, the shift opcode seeds the flag from the incoming `x_in[0]`.
- R12: With `strobe` low, or in the idle phase codes (2'b00, 2'b11), the accumulator and the flag hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Opcode |
| phase | input | 2 | Machine phase: 00 idle, 01 setup, 10 arithmetic, 11 idle |
| strobe | input | 1 | Step strobe |
| x_load | input | 1 | Parallel load request for the operand register |
| x_in | input | 12 | Parallel operand value |
| acc | output | 12 | Accumulator |
| flag | output | 1 | Flag / serial carry |
| done | output | 1 | One-cycle pulse after the twelfth step |

## Verification
Two events can land in the same clock: a parallel operand load and the setup strobe. The flag seed for the shift opcode then depends on which operand bit 0 wins. The bench drives both in one cycle, with the old and new low bits different. It then checks the flag right away, and checks the whole shifted result after twelve steps, to confirm that the new operand was both seen and kept. A second overlap is a load request arriving in the middle of an arithmetic run. This is judged by checking that the run's result still equals the original operand.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  localparam int unsigned DATA_W = 12;

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_SETUP = 2'b01;
  localparam logic [1:0] PH_ARITH = 2'b10;

  localparam logic [1:0] FN_LOAD = 2'b00;
  localparam logic [1:0] FN_NOR = 2'b01;
  localparam logic [1:0] FN_ADD = 2'b10;
  localparam logic [1:0] FN_SHIFT = 2'b11;

  typedef struct packed {
    logic res;
    logic cy;
  } bit_out_t;
endpackage

// File: rtl/sacc_bit_alu.sv
module sacc_bit_alu
  import sacc_pkg::*;
(
  input  logic [1:0] fn,
  input  logic       a_bit,
  input  logic       x_bit,
  input  logic       cin,
  output bit_out_t   out
);
  always_comb begin
    out = '{res: 1'b0, cy: cin};
    unique case (fn)
      FN_LOAD: out = '{res: x_bit, cy: cin};
      FN_NOR: out = '{res: ~(a_bit | x_bit), cy: cin};
      FN_ADD: out = '{res: a_bit ^ x_bit ^ cin,
                      cy: (a_bit & x_bit) | (a_bit & cin) | (x_bit & cin)};
      FN_SHIFT: out = '{res: cin, cy: x_bit};
      default: out = '{res: 1'b0, cy: cin};
    endcase
  end
endmodule

// File: rtl/sacc_step_counter.sv
module sacc_step_counter #(
  parameter int unsigned STEPS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic busy,
  output logic last
);
  localparam int unsigned CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] IDLE_V = CW'(STEPS);
  localparam logic [CW-1:0] LAST_V = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= IDLE_V;
    else if (clear) cnt_q <= '0;
    else if (advance && busy) cnt_q <= cnt_q + 1'b1;
  end

  assign busy = (cnt_q != IDLE_V);
  assign last = busy && (cnt_q == LAST_V);
endmodule

// File: rtl/sacc_shift_reg.sv
module sacc_shift_reg #(
  parameter int unsigned W = 12,
  parameter bit HAS_LOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic         do_load;

  generate
    if (HAS_LOAD) begin : g_load
      assign do_load = load;
    end else begin : g_noload
      assign do_load = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else if (shift) q_r <= {ser_in, q_r[W-1:1]};
    else if (do_load) q_r <= load_val;
  end

  assign q = q_r;
endmodule

// File: rtl/serial_acc_alu.sv
module serial_acc_alu
  import sacc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [1:0]   phase,
  input  logic         strobe,
  input  logic         x_load,
  input  logic [W-1:0] x_in,
  output logic [W-1:0] acc,
  output logic         flag,
  output logic         done
);
  logic         setup_stb, arith_stb, step_en, writes_state;
  logic         x_take, x_low_now, seed;
  logic         busy, last;
  logic [W-1:0] x_q, acc_q;
  logic         flag_q, done_q;
  bit_out_t     alu_o;

  assign writes_state = ~op[2];
  assign setup_stb = strobe && (phase == PH_SETUP);
  assign arith_stb = strobe && (phase == PH_ARITH);
  assign step_en = arith_stb && busy;
  assign x_take = x_load && (phase != PH_ARITH);
  assign x_low_now = x_take ? x_in[0] : x_q[0];

  always_comb begin
    unique case (op[1:0])
      FN_ADD: seed = 1'b0;
      FN_SHIFT: seed = x_low_now;
      default: seed = 1'b1;
    endcase
  end

  sacc_step_counter #(.STEPS(W)) u_cnt (
    .clk(clk), .rst(rst), .clear(setup_stb), .advance(arith_stb),
    .busy(busy), .last(last)
  );

  sacc_bit_alu u_alu (
    .fn(op[1:0]), .a_bit(acc_q[0]), .x_bit(x_q[0]), .cin(flag_q), .out(alu_o)
  );

  sacc_shift_reg #(.W(W), .HAS_LOAD(1'b1)) u_xreg (
    .clk(clk), .rst(rst), .load(x_take), .load_val(x_in),
    .shift(step_en), .ser_in(1'b0), .q(x_q)
  );

  sacc_shift_reg #(.W(W), .HAS_LOAD(1'b0)) u_areg (
    .clk(clk), .rst(rst), .load(1'b0), .load_val('0),
    .shift(step_en && writes_state), .ser_in(alu_o.res), .q(acc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= step_en && last;
      if (setup_stb && writes_state) flag_q <= seed;
      else if (step_en && writes_state) flag_q <= alu_o.cy;
    end
  end

  assign acc = acc_q;
  assign flag = flag_q;
  assign done = done_q;
endmodule

// File: rtl/serial_acc_alu_chk.sv
module serial_acc_alu_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op,
  input logic [1:0]   phase,
  input logic         strobe,
  input logic [W-1:0] acc,
  input logic         flag,
  input logic         done
);
  p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(strobe && phase == 2'b10));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_seed_add_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && phase == 2'b01 && op == 3'b010) |=> !flag);

  p_seed_one_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && phase == 2'b01 && op[2:1] == 2'b00) |=> flag);

  p_upper_hold_r9: assert property (@(posedge clk) disable iff (rst)
    op[2] |=> ($stable(acc) && $stable(flag)));

  p_quiet_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!strobe) |=> ($stable(acc) && $stable(flag)));
endmodule

bind serial_acc_alu serial_acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .phase(phase), .strobe(strobe),
  .acc(acc), .flag(flag), .done(done)
);

// File: tb/test_serial_acc_alu.sv
module test_serial_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op = 3'b000;
  logic [1:0]   phase = 2'b00;
  logic         strobe = 1'b0;
  logic         x_load = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] acc;
  logic         flag;
  logic         done;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_acc_alu i_serial_acc_alu (
    .clk(clk), .rst(rst), .op(op), .phase(phase), .strobe(strobe),
    .x_load(x_load), .x_in(x_in), .acc(acc), .flag(flag), .done(done)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_x(input logic [W-1:0] v);
    @(negedge clk); x_load = 1'b1; x_in = v; phase = 2'b00;
    @(negedge clk); x_load = 1'b0;
  endtask

  task automatic setup(input logic [2:0] o);
    @(negedge clk); op = o; phase = 2'b01; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; phase = 2'b00;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); phase = 2'b10; strobe = 1'b1;
      @(negedge clk); strobe = 1'b0;
    end
  endtask

  task automatic set_acc(input logic [W-1:0] v);
    load_x(v); setup(3'b000); steps(W);
  endtask

  task automatic t_reset;
    check("R1 acc", {1'b0, acc}, '0);
    check("R1 flag/done", {11'd0, flag, done}, '0);
    steps(3);
    check("R1 idle counter", {flag, acc}, '0);
    check("R1 no done", {12'd0, done}, '0);
  endtask

  task automatic t_load(input logic [W-1:0] b);
    load_x(b); setup(3'b000); steps(W);
    check("R5 load result", {flag, acc}, {1'b1, b});
    check("R10 done pulse", {12'd0, done}, 13'd1);
    @(negedge clk);
    check("R10 done falls", {12'd0, done}, '0);
  endtask

  task automatic t_step(input logic [W-1:0] a, input logic [W-1:0] b);
    set_acc(a); load_x(b); setup(3'b000); steps(1);
    check("R4 one step", {1'b0, acc}, {1'b0, b[0], a[W-1:1]});
    steps(W - 1);
    check("R4 run end", {1'b0, acc}, {1'b0, b});
  endtask

  task automatic t_nor(input logic [W-1:0] a, input logic [W-1:0] b);
    set_acc(a); load_x(b); setup(3'b001); steps(W);
    check("R6 nor", {flag, acc}, {1'b1, ~(a | b)});
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    set_acc(a); load_x(b); setup(3'b010);
    check("R3 add seed", {12'd0, flag}, '0);
    steps(W);
    check("R7 add", {flag, acc}, s);
  endtask

  task automatic t_shift(input logic [W-1:0] b);
    load_x(b); setup(3'b011);
    check("R3 shift seed", {12'd0, flag}, {12'd0, b[0]});
    steps(W);
    check("R8 shift", {flag, acc}, {b[W-1], b[W-2:0], b[0]});
  endtask

  task automatic t_upper(input logic [W-1:0] a, input logic [W-1:0] b);
    set_acc(a); load_x(b); setup(3'b110); steps(W);
    check("R9 upper op hold", {flag, acc}, {1'b1, a});
    check("R10 done any op", {12'd0, done}, 13'd1);
  endtask

  task automatic t_extra(input logic [W-1:0] b);
    t_load(b);
    load_x(~b); phase = 2'b10; steps(3);
    check("R10 extra strobes", {flag, acc}, {1'b1, b});
    check("R10 no second done", {12'd0, done}, '0);
  endtask

  task automatic t_load_in_arith(input logic [W-1:0] b);
    logic [W-1:0] snap;
    load_x(b); setup(3'b000); steps(5);
    @(negedge clk); phase = 2'b10; x_load = 1'b1; x_in = ~b;
    @(negedge clk); x_load = 1'b0;
    snap = acc;
    repeat (2) @(negedge clk);
    check("R12 strobe low hold", {1'b0, acc}, {1'b0, snap});
    steps(W - 5);
    check("R2 load ignored in arith", {1'b0, acc}, {1'b0, b});
  endtask

  task automatic t_collide(input logic [W-1:0] b);
    load_x({b[W-1:1], 1'b0});
    @(negedge clk); x_load = 1'b1; x_in = {b[W-1:1], 1'b1};
    op = 3'b011; phase = 2'b01; strobe = 1'b1;
    @(negedge clk); x_load = 1'b0; strobe = 1'b0; phase = 2'b00;
    check("R11 seed from new x", {12'd0, flag}, 13'd1);
    steps(W);
    check("R11 new operand kept", {1'b0, acc}, {1'b0, b[W-2:1], 1'b1, 1'b1});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load(12'hA5C);
    t_step(12'h3C1, 12'h9E6);
    t_nor(12'hF0F, 12'h0FF);
    t_nor(12'h000, 12'h000);
    t_add(12'hFFF, 12'h001);
    t_add(12'h7FF, 12'h7FF);
    for (int k = 0; k < 6; k++) t_add(W'($urandom), W'($urandom));
    t_shift(12'h801);
    t_shift(12'h6AA);
    t_upper(12'h123, 12'hEDC);
    t_extra(12'h5A5);
    t_load_in_arith(12'hC39);
    t_collide(12'h4B6);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule